// File: doc/BRIEF.md
# Branch and Move Condition Evaluator

This combinational unit decides whether a conditional control-flow or data-movement operation takes effect. A two-bit form selector chooses one of three interpretations. The first is a branch or trap that tests one of two integer flag groups. The second is a conditional move whose three-bit bank selector may also name floating-point condition sets. The third is a signed comparison of a register value against zero.

In the two flag-group forms, a four-bit condition field is applied to the chosen group's N, Z, V and C bits. In the register form, a three-bit code picks the comparison. Selector and code values that are reserved raise an illegal-operation flag. Bank values that would need floating-point condition state raise a floating-point-disabled flag. Whenever either flag is raised, the taken output is held low. The decode stage uses the three outputs to redirect fetch, commit a move or raise an exception.

Top module: `cond_eval`

## Requirements
- R1: `form_sel` decodes as follows: 0 selects the branch/trap form, 1 the move form and 2 the register form. Value 3 is reserved: it raises `illegal` and leaves `taken` low.
- R2: Flag groups are packed as {N,Z,V,C}, with N in bit 3 and C in bit 0. For condition values 0 to 7, the test is: never, Z, Z|(N^V), N^V, C|Z, C, N, V. Condition value k+8 is the inverse of value k, so 8 means always.
- R3: In the branch/trap form only `bank_sel[1:0]` is decoded: 0 tests `flags32` and 2 tests `flags64`. Values 1 and 3 raise `illegal`. `bank_sel[2]` has no effect.
- R4: In the move form, `bank_sel` values 0 to 3 raise `fp_disabled`. Value 4 tests `flags32` and value 6 tests `flags64`. Values 5 and 7 raise `illegal`.
- R5: In the register form, `reg_value` is compared as a signed number. Codes 1, 2, 3, 5, 6 and 7 take when the value is equal to zero, at most zero, below zero, nonzero, above zero and at least zero, respectively.
- R6: In the register form, codes 0 and 4 raise `illegal` and no comparison result is used.
- R7: When `illegal` or `fp_disabled` is high, `taken` is low. The two flags are never high together.
- R8: Inputs that the selected form does not use have no effect on any output. These are `cond`, `flags32`, `flags64` and `bank_sel` in the register form, and `reg_code` and `reg_value` in the flag-group forms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| form_sel | input | 2 | Form: 0 branch/trap, 1 move, 2 register, 3 reserved |
| bank_sel | input | 3 | Flag-group bank selector |
| cond | input | 4 | Condition field applied to the chosen flag group |
| flags32 | input | 4 | 32-bit condition group {N,Z,V,C} |
| flags64 | input | 4 | 64-bit condition group {N,Z,V,C} |
| reg_code | input | 3 | Register comparison code |
| reg_value | input | DATA_W | Register value, signed |
| taken | output | 1 | Condition holds and no exception |
| illegal | output | 1 | Reserved selector or code |
| fp_disabled | output | 1 | Move form selected a floating-point condition set |

## Verification
The immediate assertions assume that every input carries a known 0/1 value whenever the outputs settle, because there is no clock or reset to qualify them. The bench never leaves an input undriven. It sets all inputs to zero before the first check and changes them only between sample points, so each comparison sees a settled function of defined values.

The stimulus sweeps every form, bank and condition value across all sixteen flag patterns. In the register form it walks the codes over zero, one, minus one and both signed extremes. It then adds random vectors in which the inputs the selected form ignores are changed on purpose.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

  typedef enum logic [1:0] {
    FORM_CC2  = 2'd0,
    FORM_CC3  = 2'd1,
    FORM_REG  = 2'd2,
    FORM_RSVD = 2'd3
  } form_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccf_t;

  // Evaluate a 4-bit condition on one flag group; bit 3 inverts.
  function automatic logic cc_match(input ccf_t f, input logic [3:0] cnd);
    logic base;
    case (cnd[2:0])
      3'd0:    base = 1'b0;
      3'd1:    base = f.z;
      3'd2:    base = f.z | (f.n ^ f.v);
      3'd3:    base = f.n ^ f.v;
      3'd4:    base = f.c | f.z;
      3'd5:    base = f.c;
      3'd6:    base = f.n;
      default: base = f.v;
    endcase
    return base ^ cnd[3];
  endfunction

  // Register-vs-zero test from sign and zero indications; bit 2 inverts.
  function automatic logic reg_match(input logic sign, input logic zero,
                                     input logic [2:0] code);
    logic base;
    case (code[1:0])
      2'd1:    base = zero;
      2'd2:    base = sign | zero;
      2'd3:    base = sign;
      default: base = 1'b0;
    endcase
    return base ^ code[2];
  endfunction

  function automatic logic reg_code_reserved(input logic [2:0] code);
    return code[1:0] == 2'd0;
  endfunction

endpackage

// File: rtl/cc_bank_decode.sv
module cc_bank_decode
  import cond_eval_pkg::*;
(
  input  form_e      form,
  input  logic [2:0] bank,
  output logic       use_wide,
  output logic       bad_sel,
  output logic       fp_off
);

  always_comb begin
    use_wide = 1'b0;
    bad_sel  = 1'b0;
    fp_off   = 1'b0;
    case (form)
      FORM_CC2: begin
        use_wide = bank[1];
        bad_sel  = bank[0];
      end
      FORM_CC3: begin
        if (!bank[2]) begin
          fp_off = 1'b1;
        end else begin
          use_wide = bank[1];
          bad_sel  = bank[0];
        end
      end
      FORM_REG:  ;
      default:   bad_sel = 1'b1;
    endcase
  end

endmodule

// File: rtl/cc_cond_test.sv
module cc_cond_test
  import cond_eval_pkg::*;
#(
  parameter int GROUPS = 2
) (
  input  logic [GROUPS*4-1:0] groups,
  input  logic [$clog2(GROUPS)-1:0] pick,
  input  logic [3:0]          cnd,
  output logic                pass
);

  logic [GROUPS-1:0] lane_pass;

  for (genvar g = 0; g < GROUPS; g++) begin : g_lane
    ccf_t fl;
    assign fl           = ccf_t'(groups[g*4 +: 4]);
    assign lane_pass[g] = cc_match(fl, cnd);
  end

  assign pass = lane_pass[pick];

endmodule

// File: rtl/reg_zero_test.sv
module reg_zero_test
  import cond_eval_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] value,
  input  logic [2:0]        code,
  output logic              pass,
  output logic              reserved
);

  logic sign_bit;
  logic is_zero;

  assign sign_bit = value[DATA_W-1];
  assign is_zero  = ~|value;
  assign pass     = reg_match(sign_bit, is_zero, code);
  assign reserved = reg_code_reserved(code);

endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import cond_eval_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [1:0]        form_sel,
  input  logic [2:0]        bank_sel,
  input  logic [3:0]        cond,
  input  logic [3:0]        flags32,
  input  logic [3:0]        flags64,
  input  logic [2:0]        reg_code,
  input  logic [DATA_W-1:0] reg_value,
  output logic              taken,
  output logic              illegal,
  output logic              fp_disabled
);

  localparam int NGROUPS = 2;

  form_e form;
  logic  use_wide, bad_sel, fp_off;
  logic  cc_pass, reg_pass, reg_rsvd;
  logic  is_reg_form, exc_any;

  assign form        = form_e'(form_sel);
  assign is_reg_form = (form == FORM_REG);

  cc_bank_decode u_bank (
    .form     (form),
    .bank     (bank_sel),
    .use_wide (use_wide),
    .bad_sel  (bad_sel),
    .fp_off   (fp_off)
  );

  cc_cond_test #(.GROUPS(NGROUPS)) u_cc (
    .groups ({flags64, flags32}),
    .pick   (use_wide),
    .cnd    (cond),
    .pass   (cc_pass)
  );

  reg_zero_test #(.DATA_W(DATA_W)) u_reg (
    .value    (reg_value),
    .code     (reg_code),
    .pass     (reg_pass),
    .reserved (reg_rsvd)
  );

  assign illegal     = bad_sel | (is_reg_form & reg_rsvd);
  assign fp_disabled = fp_off;
  assign exc_any     = illegal | fp_disabled;
  assign taken       = !exc_any && (is_reg_form ? reg_pass : cc_pass);

  always_comb begin
    // R7
    exc_mask_chk: assert (!(taken && (illegal || fp_disabled)));
    // R7
    single_exc_chk: assert ($onehot0({illegal, fp_disabled}));
    // R4
    fp_scope_chk: assert (!fp_disabled || (form_sel == 2'd1 && !bank_sel[2]));
    // R6
    if (form_sel == 2'd2 && (reg_code == 3'd0 || reg_code == 3'd4))
      reg_rsvd_chk: assert (illegal && !taken);
    // R5
    if (form_sel == 2'd2 && reg_code == 3'd1)
      reg_zero_chk: assert (taken == (reg_value == '0));
    // R1
    if (form_sel == 2'd3)
      form_rsvd_chk: assert (illegal && !fp_disabled);
  end

endmodule

// File: tb/sim_cond_eval.sv
module sim_cond_eval;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]  form_sel = '0;
  logic [2:0]  bank_sel = '0;
  logic [3:0]  cond = '0;
  logic [3:0]  flags32 = '0;
  logic [3:0]  flags64 = '0;
  logic [2:0]  reg_code = '0;
  logic [63:0] reg_value = '0;
  logic taken, illegal, fp_disabled;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  cond_eval #(.DATA_W(64)) u0 (
    .form_sel(form_sel), .bank_sel(bank_sel), .cond(cond),
    .flags32(flags32), .flags64(flags64), .reg_code(reg_code),
    .reg_value(reg_value), .taken(taken), .illegal(illegal),
    .fp_disabled(fp_disabled)
  );

  function automatic bit flag_test(int grp, int c);
    bit n = grp[3], z = grp[2], v = grp[1], cy = grp[0];
    case (c)
      0: return 0;       8: return 1;
      1: return z;       9: return !z;
      2: return z || (n != v);  10: return !(z || (n != v));
      3: return n != v;  11: return n == v;
      4: return cy || z; 12: return !(cy || z);
      5: return cy;      13: return !cy;
      6: return n;       14: return !n;
      7: return v;       default: return !v;
    endcase
  endfunction

  function automatic void model(input int f, input int b, input int c,
                                input int i32, input int i64, input int rc,
                                input longint signed val,
                                output bit t, output bit il, output bit fp,
                                output string tag);
    int grp = -1;
    bit pass = 0;
    il = 0; fp = 0; tag = "R2";
    if (f == 3) begin
      il = 1; tag = "R1";
    end else if (f == 2) begin
      tag = "R5";
      case (rc)
        1: pass = (val == 0);
        2: pass = (val <= 0);
        3: pass = (val < 0);
        5: pass = (val != 0);
        6: pass = (val > 0);
        7: pass = (val >= 0);
        default: begin il = 1; tag = "R6"; end
      endcase
    end else if (f == 0) begin
      if ((b % 4) == 1 || (b % 4) == 3) begin il = 1; tag = "R3"; end
      else grp = ((b % 4) == 0) ? i32 : i64;
    end else begin
      if (b < 4) begin fp = 1; tag = "R4"; end
      else if (b == 5 || b == 7) begin il = 1; tag = "R4"; end
      else grp = (b == 4) ? i32 : i64;
    end
    if (grp >= 0) pass = flag_test(grp, c);
    t = pass && !il && !fp;
  endfunction

  task automatic run_vec(input int f, input int b, input int c, input int i32,
                         input int i64, input int rc, input longint val,
                         input string force_tag);
    bit et, ei, ef;
    string tag;
    @(posedge clk);
    #1;
    form_sel = 2'(f); bank_sel = 3'(b); cond = 4'(c);
    flags32 = 4'(i32); flags64 = 4'(i64); reg_code = 3'(rc);
    reg_value = val;
    @(negedge clk);
    model(f, b, c, i32, i64, rc, val, et, ei, ef, tag);
    if (force_tag != "") tag = force_tag;
    checks++;
    if (taken !== et || illegal !== ei || fp_disabled !== ef) begin
      errors++;
      $display("FAIL %s: form=%0d bank=%0d cond=%0d code=%0d got t/i/f=%b%b%b exp=%b%b%b",
               tag, f, b, c, rc, taken, illegal, fp_disabled, et, ei, ef);
    end
    if (ei || ef) begin
      checks++;
      if (taken !== 1'b0) begin
        errors++;
        $display("FAIL R7: taken=%b expected 0 during exception", taken);
      end
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : watchdog
    for (int cyc = 0; cyc < 150000; cyc++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    longint vals[6];
    vals[0] = 0; vals[1] = 1; vals[2] = -1;
    vals[3] = 64'sh7FFF_FFFF_FFFF_FFFF;
    vals[4] = 64'sh8000_0000_0000_0000;
    vals[5] = 64'sh0000_0001_0000_0000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: quiescent all-zero inputs: branch form, never -> nothing asserted
    run_vec(0, 0, 0, 0, 0, 0, 0, "R1");
    // R1: reserved form
    for (int b = 0; b < 8; b++) run_vec(3, b, 8, 15, 15, 1, 0, "R1");
    // R2, R3, R4: sweep flag-group forms
    for (int f = 0; f < 2; f++)
      for (int b = 0; b < 8; b++)
        for (int c = 0; c < 16; c++)
          for (int g = 0; g < 16; g++)
            run_vec(f, b, c, g, 15 - g, int'($urandom_range(7)),
                    longint'({$urandom, $urandom}), "");
    // R5, R6: register comparisons on edge values
    for (int rc = 0; rc < 8; rc++)
      for (int k = 0; k < 6; k++)
        run_vec(2, int'($urandom_range(7)), int'($urandom_range(15)),
                int'($urandom_range(15)), int'($urandom_range(15)), rc,
                vals[k], "");
    // R8: vary ignored inputs around a fixed selected condition
    for (int k = 0; k < 200; k++) begin
      run_vec(2, k % 8, k % 16, (k * 7) % 16, (k * 3) % 16, 6, 5, "R8");
      run_vec(0, (k % 2) * 4 + 2, 1, 15, 0, k % 8,
              longint'({$urandom, $urandom}), "R8");
      run_vec(1, 4, 9, 0, 4, k % 8, longint'({$urandom, $urandom}), "R8");
    end
    // random mix
    for (int k = 0; k < 2000; k++)
      run_vec(int'($urandom_range(3)), int'($urandom_range(7)),
              int'($urandom_range(15)), int'($urandom_range(15)),
              int'($urandom_range(15)), int'($urandom_range(7)),
              longint'({$urandom, $urandom}), "");
    done = 1;
    finish_run();
  end

endmodule